// File: doc/BRIEF.md
# Windowed Vertical Countdown Synchronizer

This block derives field timing from a counter clocked at twice the line rate. It replaces a free-running field oscillator. A separated vertical sync pulse can restart the counter only while the count lies inside an acceptance window. The window is narrow while the block is locked and wide while it is searching. The narrow window rejects noise on a stable broadcast signal. The wide window lets the picture pull in quickly after a channel change or a signal drop.

Each accepted sync, or a forced restart when the window closes with no sync, produces a one-cycle flyback pulse that discharges the external ramp. The same event starts the vertical blanking interval. A lock flag reports the window in use. A weak-signal input pins the window to narrow. A standard-select input chooses 525-line or 625-line timing, and the block takes it up only at a field boundary.

Top module: `vsync_countdown`

## Requirements
- R1: Reset state, applied by a synchronous active-low reset: `flyback`, `vblank` and `locked` are low, the window is wide, and the count is 0. With no sync, the first flyback comes 545 clock cycles after reset is released in the 525-line standard.
- R2: Narrow window. A sync pulse high during count c restarts the field only for 514 ≤ c ≤ 526 (`std_625`=0) or 614 ≤ c ≤ 626 (`std_625`=1). The flyback cycle holds count 1, so the field period in cycles then equals c.
- R3: Wide window. Sync is accepted for 384 ≤ c ≤ 544 (`std_625`=0) or 484 ≤ c ≤ 644 (`std_625`=1).
- R4: The window becomes narrow, and `locked` goes high, after two restarts in a row that each coincide with the nominal count (525, or 625 when `std_625`=1).
- R5: The window becomes wide after eight restarts in a row that do not coincide with the nominal count. Forced restarts count as non-coincident.
- R6: When no sync is accepted, the counter restarts at the window's last count, so the field period equals that count. A sync pulse on the last count produces only one restart.
- R7: `flyback` is high for exactly one cycle. It is high in the cycle after the count that accepted the sync. Sync outside the window is ignored.
- R8: A coincident restart clears the run of non-coincident ones, and a non-coincident restart clears the run of coincident ones.
- R9: `vblank` rises together with `flyback`. It stays high through count 19 and falls when the count reaches 20, which is 19 cycles in all.
- R10: While `weak_sig` is high, the narrow window is in force and `locked` is high in the same cycle. The coincidence history keeps being updated.
- R11: `std_625` is sampled only at a restart (and during reset), so a change in mid-field does not move the current window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the line rate |
| rst_n | input | 1 | Synchronous active-low reset |
| vsync | input | 1 | Separated vertical sync, high for the counts it covers |
| weak_sig | input | 1 | Weak-signal flag, forces the narrow window |
| std_625 | input | 1 | Standard select: 0 = 525 lines, 1 = 625 lines |
| flyback | output | 1 | One-cycle ramp-discharge pulse at each field restart |
| vblank | output | 1 | Vertical blanking, from restart to count 20 |
| locked | output | 1 | High while the narrow window is in use |

## Verification
Two functions can fall in the same cycle: the acceptance of a sync pulse and the forced restart at the window's closing count. The bench provokes this by placing sync exactly on count 526 in the narrow window and on count 544 in the wide window. In each case it judges that one field of exactly that length results and that the next flyback is not doubled. A second coincidence is a standard change that arrives in the same field as a coincident restart. That restart must still be judged against the old standard's window and nominal count.

// File: rtl/vcd_pkg.sv
// Package: shared types and bound helpers for the vertical countdown.
// Assumes counts are unsigned and the window offsets keep all bounds positive.
package vcd_pkg;

    typedef enum logic {
        WIN_WIDE   = 1'b0,
        WIN_NARROW = 1'b1
    } win_mode_e;

    // Lower bound of a window around a nominal count.
    function automatic int win_lo(input int nominal, input int below);
        return nominal - below;
    endfunction

    // Upper bound of a window around a nominal count.
    function automatic int win_hi(input int nominal, input int above);
        return nominal + above;
    endfunction

endpackage

// File: rtl/vcd_window.sv
// Window decoder: computes the narrow and wide bounds for both standards,
// holds the standard selected at the last restart, and flags whether the
// present count is inside the window in force, at its closing count, or at
// the nominal field length.
// Assumes: every bound fits in CNT_W bits and the low bounds are above 1.
module vcd_window
    import vcd_pkg::*;
#(
    parameter int CNT_W     = 10,
    parameter int NOM_A     = 525,
    parameter int NOM_B     = 625,
    parameter int NAR_BELOW = 11,
    parameter int NAR_ABOVE = 1,
    parameter int WID_BELOW = 141,
    parameter int WID_ABOVE = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             std_sel,
    input  logic             reload,
    input  win_mode_e        mode,
    input  logic [CNT_W-1:0] cnt,
    output logic             open_win,
    output logic             at_close,
    output logic             at_nom,
    output logic             std_q
);
    localparam int N_STD = 2;

    logic [CNT_W-1:0] nar_lo [N_STD];
    logic [CNT_W-1:0] nar_hi [N_STD];
    logic [CNT_W-1:0] wid_lo [N_STD];
    logic [CNT_W-1:0] wid_hi [N_STD];
    logic [CNT_W-1:0] nom_v  [N_STD];

    // One set of bounds per supported standard.
    for (genvar s = 0; s < N_STD; s++) begin : g_std
        localparam int NOM = (s == 0) ? NOM_A : NOM_B;
        assign nom_v[s]  = CNT_W'(NOM);
        assign nar_lo[s] = CNT_W'(win_lo(NOM, NAR_BELOW));
        assign nar_hi[s] = CNT_W'(win_hi(NOM, NAR_ABOVE));
        assign wid_lo[s] = CNT_W'(win_lo(NOM, WID_BELOW));
        assign wid_hi[s] = CNT_W'(win_hi(NOM, WID_ABOVE));
    end

    // Take up the standard only at a field restart (or during reset).
    always_ff @(posedge clk) begin
        if (!rst_n)      std_q <= std_sel;
        else if (reload) std_q <= std_sel;
    end

    logic [CNT_W-1:0] lo_sel, hi_sel;

    // Pick the bounds of the window in force and compare against the count.
    always_comb begin
        lo_sel   = (mode == WIN_NARROW) ? nar_lo[std_q] : wid_lo[std_q];
        hi_sel   = (mode == WIN_NARROW) ? nar_hi[std_q] : wid_hi[std_q];
        open_win = (cnt >= lo_sel) && (cnt <= hi_sel);
        at_close = (cnt == hi_sel);
        at_nom   = (cnt == nom_v[std_q]);
    end

    // R11: the standard in use changes only on a cycle that restarts the field.
    p_std_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(reload)) |-> $stable(std_q));

endmodule

// File: rtl/vcd_lock.sv
// Lock tracker: counts runs of coincident and non-coincident restarts and
// switches the window mode. Each run counter saturates at its threshold.
// Assumes: 'coinc' is only ever high together with 'reload'.
module vcd_lock
    import vcd_pkg::*;
#(
    parameter int LOCK_RUN   = 2,
    parameter int UNLOCK_RUN = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      reload,
    input  logic      coinc,
    output win_mode_e mode_q
);
    localparam int HW = $clog2(LOCK_RUN + 1);
    localparam int MW = $clog2(UNLOCK_RUN + 1);

    logic [HW-1:0] hit_run;
    logic [MW-1:0] miss_run;

    // Update both run counters and the mode at each restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_run  <= '0;
            miss_run <= '0;
            mode_q   <= WIN_WIDE;
        end else if (reload) begin
            if (coinc) begin
                miss_run <= '0;
                if (int'(hit_run) < LOCK_RUN) hit_run <= hit_run + 1'b1;
                if (int'(hit_run) + 1 >= LOCK_RUN) mode_q <= WIN_NARROW;
            end else begin
                hit_run <= '0;
                if (int'(miss_run) < UNLOCK_RUN) miss_run <= miss_run + 1'b1;
                if (int'(miss_run) + 1 >= UNLOCK_RUN) mode_q <= WIN_WIDE;
            end
        end
    end

    // R4: entering narrow mode needs a coincident restart in the cycle before.
    p_lock_on_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == WIN_NARROW && $past(mode_q) == WIN_WIDE) |-> $past(coinc));

    // R5: leaving narrow mode needs a non-coincident restart in the cycle before.
    p_unlock_on_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == WIN_WIDE && $past(mode_q) == WIN_NARROW) |-> ($past(reload) && !$past(coinc)));

    // R8: the two runs are never both non-zero.
    p_runs_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_run == '0) || (miss_run == '0));

endmodule

// File: rtl/vcd_counter.sv
// Field counter: counts at twice the line rate, reloads to 1 on a restart so
// the flyback cycle is count 1, and drives the flyback pulse and blanking.
// Assumes: 'reload' never arrives at count 1 (all windows open later).
module vcd_counter #(
    parameter int CNT_W     = 10,
    parameter int BLANK_END = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    output logic [CNT_W-1:0] cnt,
    output logic             flyback,
    output logic             vblank
);
    localparam logic [CNT_W-1:0] BLANK_LAST = CNT_W'(BLANK_END - 1);

    // Advance the count or reload it at a field restart.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (reload) cnt <= CNT_W'(1);
        else             cnt <= cnt + 1'b1;
    end

    // Register the restart request into the flyback pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) flyback <= 1'b0;
        else        flyback <= reload;
    end

    // Blanking latch: set at a restart, cleared when the count reaches BLANK_END.
    always_ff @(posedge clk) begin
        if (!rst_n)                     vblank <= 1'b0;
        else if (reload)                vblank <= 1'b1;
        else if (cnt == BLANK_LAST)     vblank <= 1'b0;
    end

    // R7: the flyback pulse is one cycle wide.
    p_flyback_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flyback |=> !flyback);

    // R9: blanking is on whenever flyback is.
    p_blank_with_flyback_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flyback |-> vblank);

endmodule

// File: rtl/vsync_countdown.sv
// Top: windowed vertical countdown. A sync pulse inside the window, or the
// window's closing count, requests a restart; the request is registered into
// the flyback pulse and reloads the counter. Weak signal forces narrow mode.
// Assumes: vsync is already separated and synchronous to clk.
module vsync_countdown
    import vcd_pkg::*;
#(
    parameter int CNT_W      = 10,
    parameter int NOM_A      = 525,
    parameter int NOM_B      = 625,
    parameter int NAR_BELOW  = 11,
    parameter int NAR_ABOVE  = 1,
    parameter int WID_BELOW  = 141,
    parameter int WID_ABOVE  = 19,
    parameter int LOCK_RUN   = 2,
    parameter int UNLOCK_RUN = 8,
    parameter int BLANK_END  = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vsync,
    input  logic weak_sig,
    input  logic std_625,
    output logic flyback,
    output logic vblank,
    output logic locked
);
    logic [CNT_W-1:0] cnt;
    logic             open_win, at_close, at_nom, std_q;
    logic             reload, coinc;
    win_mode_e        mode_q, mode_eff;

    // Mode in force: the tracked mode, overridden to narrow on weak signal.
    always_comb begin
        mode_eff = weak_sig ? WIN_NARROW : mode_q;
        reload   = (vsync && open_win) || at_close;
        coinc    = reload && at_nom;
        locked   = (mode_eff == WIN_NARROW);
    end

    vcd_window #(
        .CNT_W(CNT_W), .NOM_A(NOM_A), .NOM_B(NOM_B),
        .NAR_BELOW(NAR_BELOW), .NAR_ABOVE(NAR_ABOVE),
        .WID_BELOW(WID_BELOW), .WID_ABOVE(WID_ABOVE)
    ) u_window (
        .clk(clk), .rst_n(rst_n), .std_sel(std_625), .reload(reload),
        .mode(mode_eff), .cnt(cnt), .open_win(open_win),
        .at_close(at_close), .at_nom(at_nom), .std_q(std_q)
    );

    vcd_lock #(
        .LOCK_RUN(LOCK_RUN), .UNLOCK_RUN(UNLOCK_RUN)
    ) u_lock (
        .clk(clk), .rst_n(rst_n), .reload(reload), .coinc(coinc), .mode_q(mode_q)
    );

    vcd_counter #(
        .CNT_W(CNT_W), .BLANK_END(BLANK_END)
    ) u_counter (
        .clk(clk), .rst_n(rst_n), .reload(reload),
        .cnt(cnt), .flyback(flyback), .vblank(vblank)
    );

    // R6: the count never runs past the closing count of the window in force.
    p_no_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(at_close) |-> (cnt == CNT_W'(1)));

    // R7: a flyback pulse follows only a sync inside the window or a closing count.
    p_flyback_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flyback) |-> ($past(vsync && open_win) || $past(at_close)));

    // R10: weak signal always shows as locked.
    p_weak_locks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        weak_sig |-> locked);

endmodule

// File: tb/test_vsync_countdown.sv
// Bench: drives fields with sync at chosen counts and checks field lengths,
// blanking and lock against values worked out from the requirements.
module test_vsync_countdown;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vsync = 1'b0;
    logic weak_sig = 1'b0;
    logic std_625 = 1'b0;
    logic flyback, vblank, locked;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vsync_countdown i_vsync_countdown (
        .clk(clk), .rst_n(rst_n), .vsync(vsync), .weak_sig(weak_sig),
        .std_625(std_625), .flyback(flyback), .vblank(vblank), .locked(locked)
    );

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    // Starts at the negedge of a flyback cycle (count 1), ends at the next one.
    task automatic run_field(input int sync_at, input int exp_p, input string rq);
        int c = 1;
        int bad = 0;
        bit fin = 1'b0;
        while (!fin) begin
            if (vblank !== (c < 20)) bad++;
            vsync = (c == sync_at);
            @(posedge clk);
            @(negedge clk);
            vsync = 1'b0;
            c++;
            if (flyback === 1'b1 || c > 2000) fin = 1'b1;
        end
        check(c - 1 == exp_p, rq, c - 1, exp_p);
        check(bad == 0, "R9 blanking span", bad, 0);
    endtask

    task automatic chk_lock(input bit exp, input string rq);
        check(locked === exp, rq, int'(locked), int'(exp));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(flyback === 1'b0, "R1 flyback", int'(flyback), 0);
        check(vblank === 1'b0, "R1 vblank", int'(vblank), 0);
        chk_lock(1'b0, "R1 locked");
        n = 0;
        while (flyback !== 1'b1 && n < 2000) begin
            @(posedge clk);
            @(negedge clk);
            n++;
        end
        check(n == 545, "R1 R6 first timeout", n, 545);

        // R4: two coincidences lock
        run_field(525, 525, "R4 coincident field 1");
        chk_lock(1'b0, "R4 one hit not enough");
        run_field(525, 525, "R4 coincident field 2");
        chk_lock(1'b1, "R4 locked after two");

        // R2 R7: narrow window edges, outside sync ignored
        run_field(500, 526, "R7 sync below narrow ignored");
        run_field(514, 514, "R2 narrow low edge");
        run_field(513, 526, "R2 just below narrow");
        run_field(526, 526, "R6 sync on closing count");
        for (int k = 0; k < 3; k++) run_field(0, 526, "R6 narrow timeout");
        chk_lock(1'b1, "R5 seven misses keep lock");
        run_field(0, 526, "R6 narrow timeout 8");
        chk_lock(1'b0, "R5 eighth miss unlocks");

        // R3: wide window edges
        run_field(384, 384, "R3 wide low edge");
        run_field(383, 544, "R3 below wide ignored");
        run_field(544, 544, "R3 R6 wide closing count");

        // R10: weak forces narrow at once
        weak_sig = 1'b1;
        #0;
        chk_lock(1'b1, "R10 weak locks");
        run_field(400, 526, "R10 narrow in force");
        weak_sig = 1'b0;
        #0;
        chk_lock(1'b0, "R10 release returns to wide");

        // R8: interrupted coincidence run
        run_field(525, 525, "R8 hit");
        run_field(400, 400, "R8 miss");
        run_field(525, 525, "R8 hit again");
        chk_lock(1'b0, "R8 run was cleared");
        run_field(525, 525, "R8 second hit");
        chk_lock(1'b1, "R8 locked");

        // R11: standard taken at restart only
        std_625 = 1'b1;
        run_field(525, 525, "R11 old window kept");
        chk_lock(1'b1, "R11 still locked");
        run_field(625, 625, "R4 625 nominal");
        run_field(613, 626, "R2 625 below narrow");
        run_field(614, 614, "R2 625 narrow low edge");
        for (int k = 0; k < 5; k++) run_field(0, 626, "R6 625 timeout");
        chk_lock(1'b1, "R5 625 seven misses");
        run_field(0, 626, "R6 625 timeout 8");
        chk_lock(1'b0, "R5 625 unlock");
        run_field(484, 484, "R3 625 wide low edge");
        run_field(0, 644, "R3 625 wide timeout");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule